// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between up to eight peripheral interrupt sources and a processor that has only one interrupt request input. It catches rising edges on its request lines and holds them as pending. It filters the pending requests through a mask and selects the most urgent one by fixed priority. When that request may be forwarded, it raises a single interrupt request output. The processor answers with a one-cycle acknowledge pulse. On the next cycle the controller presents an 8-bit vector and a valid strobe, and it moves the chosen request from pending to in-service.

Software uses a small write-only register port. Through it software sets the mask, the vector base and the service discipline, and it signals the end of a handler. In sequential discipline, nothing new is forwarded while any request is in service. Requests that arrive in that time wait and are handed over one by one after each end-of-handler command. In nested discipline, a request of strictly higher priority than the most urgent in-service one preempts it. After the preempting handler ends, the held lower-priority service continues.

Top module: `prio_intc`

## Requirements
- R1: Each of the eight lines `irq_i[0..7]` becomes pending on a 0-to-1 transition only. A line that stays high after its request has been acknowledged does not become pending again.
- R2: The mask register has write address 0, and bit n masks line n. A masked line still records its rising edge as pending but cannot raise `intr_o`. Clearing the mask bit later lets the stored request raise `intr_o`.
- R3: `intr_o` is registered. It is high in the cycle after a forwardable request exists. It goes low in the cycle after an `inta_i` pulse. It also goes low if its only eligible request becomes masked before the acknowledge.
- R4: The vector equals base bits [7:3] followed by the 3-bit line number. The base register has write address 1.
- R5: `vec_vld_o` is high for exactly the one cycle after an `inta_i` cycle. `vec_o` holds its value between acknowledges.
- R6: Sequential discipline is selected when bit 0 of the mode register (write address 2) is 0. In this discipline `intr_o` stays low while any request is in service.
- R7: Nested discipline is selected when mode bit 0 is 1. In this discipline only a request with a lower line number than the lowest-numbered in-service line is forwarded.
- R8: Priority is fixed: line 0 is the most urgent and line 7 the least.
- R9: An acknowledge clears the pending bit of the chosen line and marks that line in service. Any write to address 3 is an end-of-handler command. It releases the lowest-numbered in-service line.
- R10: An acknowledge with no forwardable request returns the line-7 vector as a spurious vector. It changes neither the pending nor the in-service state.
- R11: After reset, `intr_o`, `vec_vld_o` and `vec_o` are 0. The mask and base are 0, the mode is sequential, and nothing is pending or in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 8 | Peripheral request lines, edge-triggered |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 mask, 1 base, 2 mode, 3 end-of-handler |
| cfg_wdata | input | 8 | Register write data |
| inta_i | input | 1 | Processor acknowledge pulse, one cycle |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector of the acknowledged request |
| vec_vld_o | output | 1 | Vector valid strobe |

## Verification
The assertions assume that `inta_i` is a one-cycle pulse and never high on two consecutive cycles. The stimulus always drops it for at least one cycle after each pulse. The base check compares the vector with the base held in the acknowledge cycle, so a base write in that same cycle is legal. The random phase writes configuration at any time, end-of-handler commands included, and may change the mode while requests are in service. A per-cycle reference model follows every such case.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int DEF_N_IRQ  = 8;
  localparam int DEF_DATA_W = 8;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_BASE = 2'd1,
    SEL_MODE = 2'd2,
    SEL_EOI  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int N_IRQ  = DEF_N_IRQ,
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [N_IRQ-1:0]  mask_o,
  output logic [DATA_W-1:0] base_o,
  output logic              nested_o,
  output logic              eoi_o
);
  cfg_sel_e sel;
  assign sel   = cfg_sel_e'(addr);
  assign eoi_o = we && (sel == SEL_EOI);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o   <= '0;
      base_o   <= '0;
      nested_o <= 1'b0;
    end else if (we) begin
      case (sel)
        SEL_MASK: mask_o   <= wdata[N_IRQ-1:0];
        SEL_BASE: base_o   <= wdata;
        SEL_MODE: nested_o <= wdata[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prio_intc_edge.sv
module prio_intc_edge #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] clr_i,
  output logic [N_IRQ-1:0] pend_o
);
  logic [N_IRQ-1:0] irq_d;
  logic [N_IRQ-1:0] rise;

  assign rise = irq_i & ~irq_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_d  <= '0;
      pend_o <= '0;
    end else begin
      irq_d  <= irq_i;
      pend_o <= (pend_o & ~clr_i) | rise;
    end
  end
endmodule

// File: rtl/prio_intc_pick.sv
module prio_intc_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     one_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec_i[k]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(k);
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_one
    assign one_o[g] = hit_o && (idx_o == IDX_W'(g));
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int N_IRQ  = DEF_N_IRQ,
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              inta_i,
  output logic              intr_o,
  output logic [DATA_W-1:0] vec_o,
  output logic              vec_vld_o
);
  localparam int IDX_W = $clog2(N_IRQ);

  logic [N_IRQ-1:0]  mask_q;
  logic [DATA_W-1:0] base_q;
  logic              nested_q;
  logic              eoi;
  logic [N_IRQ-1:0]  pend;
  logic [N_IRQ-1:0]  isr_q;
  logic [N_IRQ-1:0]  elig;
  logic              e_hit, s_hit;
  logic [IDX_W-1:0]  e_idx, s_idx;
  logic [N_IRQ-1:0]  e_one, s_one;
  logic              fwd;
  logic [N_IRQ-1:0]  take;
  logic [N_IRQ-1:0]  done;
  logic [IDX_W-1:0]  sel_idx;

  prio_intc_regs #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .mask_o(mask_q), .base_o(base_q), .nested_o(nested_q), .eoi_o(eoi)
  );

  prio_intc_edge #(.N_IRQ(N_IRQ)) u_edge (
    .clk(clk), .rst(rst), .irq_i(irq_i), .clr_i(take), .pend_o(pend)
  );

  assign elig = pend & ~mask_q;

  prio_intc_pick #(.N(N_IRQ), .IDX_W(IDX_W)) u_pick_req (
    .vec_i(elig), .hit_o(e_hit), .idx_o(e_idx), .one_o(e_one)
  );

  prio_intc_pick #(.N(N_IRQ), .IDX_W(IDX_W)) u_pick_isr (
    .vec_i(isr_q), .hit_o(s_hit), .idx_o(s_idx), .one_o(s_one)
  );

  always_comb begin
    if (nested_q) fwd = e_hit && (!s_hit || (e_idx < s_idx));
    else          fwd = e_hit && !s_hit;
  end

  assign take    = (inta_i && fwd) ? e_one : '0;
  assign done    = eoi ? s_one : '0;
  assign sel_idx = fwd ? e_idx : {IDX_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q     <= '0;
      intr_o    <= 1'b0;
      vec_o     <= '0;
      vec_vld_o <= 1'b0;
    end else begin
      isr_q     <= (isr_q & ~done) | take;
      intr_o    <= fwd && !inta_i;
      vec_vld_o <= inta_i;
      if (inta_i) vec_o <= {base_q[DATA_W-1:IDX_W], sel_idx};
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int N_IRQ  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              inta_i,
  input logic              intr_o,
  input logic [DATA_W-1:0] vec_o,
  input logic              vec_vld_o,
  input logic [DATA_W-1:0] base_q,
  input logic              nested_q,
  input logic [N_IRQ-1:0]  isr_q,
  input logic [N_IRQ-1:0]  elig
);
  localparam int IDX_W = $clog2(N_IRQ);

  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    vec_vld_o |-> $past(inta_i)); // R5

  AST_VEC_BASE: assert property (@(posedge clk) disable iff (rst)
    vec_vld_o |-> (vec_o[DATA_W-1:IDX_W] == $past(base_q[DATA_W-1:IDX_W]))); // R4

  AST_INTR_DROP_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    inta_i |=> !intr_o); // R3

  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(!nested_q) && $past(|isr_q)) |-> !intr_o); // R6

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    intr_o |-> $past(|elig)); // R2
endmodule

bind prio_intc prio_intc_chk #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .inta_i(inta_i), .intr_o(intr_o), .vec_o(vec_o),
  .vec_vld_o(vec_vld_o), .base_q(base_q), .nested_q(nested_q),
  .isr_q(isr_q), .elig(elig)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       inta = 1'b0;
  logic       intr;
  logic [7:0] vec;
  logic       vld;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  // reference state
  logic [7:0] m_req, m_isr, m_prev, m_mask, m_base;
  logic       m_nested, m_intr, m_vld;
  logic [7:0] m_vec;

  always #4 clk = ~clk;

  prio_intc dut (
    .clk(clk), .rst(rst), .irq_i(irq), .cfg_we(we), .cfg_addr(addr),
    .cfg_wdata(wdata), .inta_i(inta), .intr_o(intr), .vec_o(vec), .vec_vld_o(vld)
  );

  function automatic int lowest(input logic [7:0] v);
    for (int k = 0; k < 8; k++) if (v[k]) return k;
    return 8;
  endfunction

  task automatic model_step();
    logic [7:0] el, nreq, nisr;
    int ei, si;
    logic f;
    if (rst) begin
      m_req = 0; m_isr = 0; m_prev = 0; m_mask = 0; m_base = 0;
      m_nested = 0; m_intr = 0; m_vld = 0; m_vec = 0;
      return;
    end
    el = m_req & ~m_mask;
    ei = lowest(el);
    si = lowest(m_isr);
    f  = (ei < 8) && (m_nested ? (ei < si) : (si == 8));
    nreq = m_req;
    nisr = m_isr;
    if (we && addr == 2'd3 && si < 8) nisr[si] = 1'b0;
    if (inta && f) begin
      nreq[ei] = 1'b0;
      nisr[ei] = 1'b1;
    end
    nreq = nreq | (irq & ~m_prev);
    m_intr = f && !inta;
    m_vld  = inta;
    if (inta) m_vec = {m_base[7:3], f ? 3'(ei) : 3'd7};
    if (we && addr == 2'd0) m_mask = wdata;
    if (we && addr == 2'd1) m_base = wdata;
    if (we && addr == 2'd2) m_nested = wdata[0];
    m_prev = irq;
    m_req = nreq;
    m_isr = nisr;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({7'd0, intr}, {7'd0, m_intr}, "R3 intr model");
    chk({7'd0, vld}, {7'd0, m_vld}, "R5 valid model");
    chk(vec, m_vec, "R4 vector model");
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic ack(input logic [7:0] exp, input string tag);
    inta = 1'b1;
    tick();
    inta = 1'b0;
    chk({7'd0, vld}, 8'd1, tag);
    chk(vec, exp, tag);
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    bit last_ack;
    seed = 32'h1cc5;
    void'($urandom(seed));
    @(negedge clk);
    settle(4);
    rst = 1'b0;
    // R11 reset state
    chk({7'd0, intr}, 8'd0, "R11 intr after reset");
    chk({7'd0, vld}, 8'd0, "R11 vld after reset");
    chk(vec, 8'd0, "R11 vec after reset");
    settle(1);
    wr(2'd1, 8'h40);

    // R8 priority, R6 sequential holding
    irq = 8'b0000_1010;
    settle(2);
    chk({7'd0, intr}, 8'd1, "R3 intr raised");
    ack(8'h41, "R8 line1 before line3");
    settle(3);
    chk({7'd0, intr}, 8'd0, "R6 sequential hold");
    wr(2'd3, 8'h00);
    settle(1);
    chk({7'd0, intr}, 8'd1, "R9 eoi releases next");
    ack(8'h43, "R9 line3 after eoi");
    wr(2'd3, 8'h00);
    settle(3);
    chk({7'd0, intr}, 8'd0, "R1 held level not relatched");
    irq = 8'h00;
    settle(1);

    // R2 masked yet latched
    wr(2'd0, 8'h10);
    irq[4] = 1'b1;
    settle(3);
    chk({7'd0, intr}, 8'd0, "R2 masked no intr");
    wr(2'd0, 8'h00);
    settle(1);
    chk({7'd0, intr}, 8'd1, "R2 unmask delivers");
    ack(8'h44, "R2 masked vector");
    wr(2'd3, 8'h00);

    // R3 mask before ack drops intr
    irq[5] = 1'b1;
    settle(2);
    chk({7'd0, intr}, 8'd1, "R3 line5 raised");
    wr(2'd0, 8'h20);
    settle(1);
    chk({7'd0, intr}, 8'd0, "R3 dropped by mask");
    wr(2'd0, 8'h00);
    settle(1);
    ack(8'h45, "R3 line5 vector");
    wr(2'd3, 8'h00);
    irq = 8'h00;
    settle(2);

    // R7 nested mode
    wr(2'd2, 8'h01);
    irq[6] = 1'b1;
    settle(2);
    ack(8'h46, "R7 line6 first");
    irq[2] = 1'b1;
    settle(2);
    chk({7'd0, intr}, 8'd1, "R7 preempt by line2");
    ack(8'h42, "R7 line2 preempts");
    irq[7] = 1'b1;
    settle(2);
    chk({7'd0, intr}, 8'd0, "R7 line7 blocked");
    wr(2'd3, 8'h00);
    settle(2);
    chk({7'd0, intr}, 8'd0, "R7 line6 still blocks line7");
    wr(2'd3, 8'h00);
    settle(1);
    chk({7'd0, intr}, 8'd1, "R7 line7 after both eoi");
    ack(8'h47, "R7 line7 vector");
    wr(2'd3, 8'h00);
    irq = 8'h00;
    settle(2);

    // R10 spurious
    ack(8'h47, "R10 spurious vector");
    settle(2);
    chk({7'd0, intr}, 8'd0, "R10 no state change");
    irq[0] = 1'b1;
    settle(2);
    ack(8'h40, "R10 real request after spurious");
    wr(2'd3, 8'h00);
    irq = 8'h00;
    wr(2'd2, 8'h00);

    // random phase
    last_ack = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      irq = irq ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
      inta = !last_ack && ($urandom % 6 == 0);
      last_ack = inta;
      we = 1'b0;
      case ($urandom % 60)
        0, 1, 2, 3, 4, 5: begin we = 1'b1; addr = 2'd3; wdata = 8'($urandom); end
        6: begin we = 1'b1; addr = 2'd0; wdata = 8'($urandom) & 8'($urandom); end
        7: begin we = 1'b1; addr = 2'd1; wdata = 8'($urandom); end
        8: begin we = 1'b1; addr = 2'd2; wdata = 8'($urandom); end
        default: ;
      endcase
      tick();
    end
    we = 1'b0;
    inta = 1'b0;
    settle(2);

    done_flag = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule